// File: doc/BRIEF.md
# Phase-Counter Minimum Sorter and Motion Accumulator

The block sits behind a bank of free-running period counters. Each counter measures the same input signal, and each runs on one of several equally spaced phases of a fast clock. Edges near a clock transition can make one counter read one count high or low. To resist this, the block does not pick one counter by phase location. It looks at the smallest count and at the largest count minus one. The sub-clock fraction from a phase interpolator then decides between those two candidates.

On every sample strobe the chosen integer is registered. It is also packed with the fraction into one fixed-point word, whose unit is one fast-clock period divided by the phase count. The integer minus a reference count gives an instantaneous velocity term. That term is added into a running displacement total, which software-free control logic can zero with a clear input.

Top module: `phase_count_selector`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become zero after that edge.
- R2: When the minimum count equals the maximum count minus one, that shared value is selected as the integer part.
- R3: When the minimum and the maximum minus one differ and `frac_in` is nonzero, the maximum minus one is selected.
- R4: When the minimum and the maximum minus one differ and `frac_in` is zero, the minimum is selected.
- R5: `fixed_out` equals the selected integer shifted left by FRAC_W bits, with `frac_in` in bits [FRAC_W-1:0].
- R6: `vel_out` equals the selected integer minus `ref_count`, modulo 2^CNT_W (two's complement).
- R7: On each strobe without a clear, `disp_out` grows by `vel_out` sign-extended to ACC_W bits.
- R8: `total_clear` zeroes `disp_out` on the next edge and takes priority over a strobe that arrives in the same cycle. `int_out`, `fixed_out` and `vel_out` still update from that strobe.
- R9: All results appear on the clock edge that samples `sample_valid` high. Without a strobe (and without a clear, for `disp_out`), all outputs hold their values even when the data inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe: new counts and fraction are present |
| total_clear | input | 1 | Zero the displacement total |
| phase_counts | input | NUM_PH*CNT_W | Packed counts, lane i in bits [i*CNT_W +: CNT_W] |
| frac_in | input | FRAC_W | Sub-clock fraction from the phase interpolator |
| ref_count | input | CNT_W | Reference period count |
| int_out | output | CNT_W | Selected integer part |
| fixed_out | output | CNT_W+FRAC_W | {integer, fraction} word |
| vel_out | output | CNT_W | Integer minus reference |
| disp_out | output | ACC_W | Accumulated velocity |

## Verification
The hardest case to reach is a disagreement between the minimum and the maximum minus one. This only happens when a lane is off by two or more, or when all lanes are equal. The stimulus table builds each count vector from a base value plus per-lane masks for minus one, minus two and plus one. This lets it place outliers on chosen lanes and pair each one with a zero or nonzero fraction. A clear that arrives together with a strobe, and data changes made while no strobe is present, are driven in directed steps after the table.

// File: rtl/minsort_pkg.sv
package minsort_pkg;
  typedef enum logic [1:0] {
    SRC_AGREE = 2'd0,
    SRC_MAXM1 = 2'd1,
    SRC_MIN   = 2'd2
  } pick_src_e;
endpackage

// File: rtl/phase_extremes.sv
module phase_extremes #(
  parameter int NUM_PH = 8,
  parameter int CNT_W  = 32
) (
  input  logic [NUM_PH*CNT_W-1:0] lanes_flat,
  output logic [CNT_W-1:0]        min_v,
  output logic [CNT_W-1:0]        max_v
);
  logic [CNT_W-1:0] lane [NUM_PH];

  genvar g;
  generate
    for (g = 0; g < NUM_PH; g++) begin : g_unpack
      assign lane[g] = lanes_flat[g*CNT_W +: CNT_W];
    end
  endgenerate

  always_comb begin
    min_v = lane[0];
    max_v = lane[0];
    for (int i = 1; i < NUM_PH; i++) begin
      if (lane[i] < min_v) min_v = lane[i];
      if (lane[i] > max_v) max_v = lane[i];
    end
  end
endmodule

// File: rtl/int_chooser.sv
module int_chooser
  import minsort_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 3
) (
  input  logic [CNT_W-1:0]  min_v,
  input  logic [CNT_W-1:0]  max_v,
  input  logic [FRAC_W-1:0] frac,
  output logic [CNT_W-1:0]  pick
);
  logic [CNT_W-1:0] max_m1;
  pick_src_e        src;

  assign max_m1 = max_v - CNT_W'(1);

  always_comb begin
    if (min_v == max_m1)    src = SRC_AGREE;
    else if (frac != '0)    src = SRC_MAXM1;
    else                    src = SRC_MIN;
  end

  always_comb begin
    unique case (src)
      SRC_MAXM1: pick = max_m1;
      default:   pick = min_v;
    endcase
  end
endmodule

// File: rtl/motion_accum.sv
module motion_accum #(
  parameter int CNT_W = 32,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             clr,
  input  logic [CNT_W-1:0] pick,
  input  logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] vel_q,
  output logic [ACC_W-1:0] disp_q
);
  logic [CNT_W-1:0] vel_d;
  logic [ACC_W-1:0] vel_ext;

  assign vel_d   = pick - ref_count;
  assign vel_ext = ACC_W'(signed'(vel_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      vel_q  <= '0;
      disp_q <= '0;
    end else begin
      if (upd) vel_q <= vel_d;
      if (clr)      disp_q <= '0;
      else if (upd) disp_q <= disp_q + vel_ext;
    end
  end
endmodule

// File: rtl/phase_count_selector.sv
module phase_count_selector #(
  parameter int NUM_PH = 8,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 3,
  parameter int ACC_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_valid,
  input  logic                      total_clear,
  input  logic [NUM_PH*CNT_W-1:0]   phase_counts,
  input  logic [FRAC_W-1:0]         frac_in,
  input  logic [CNT_W-1:0]          ref_count,
  output logic [CNT_W-1:0]          int_out,
  output logic [CNT_W+FRAC_W-1:0]   fixed_out,
  output logic [CNT_W-1:0]          vel_out,
  output logic [ACC_W-1:0]          disp_out
);
  localparam int FIX_W = CNT_W + FRAC_W;

  logic [CNT_W-1:0] min_v, max_v, pick;

  phase_extremes #(.NUM_PH(NUM_PH), .CNT_W(CNT_W)) u_ext (
    .lanes_flat (phase_counts),
    .min_v      (min_v),
    .max_v      (max_v)
  );

  int_chooser #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_pick (
    .min_v (min_v),
    .max_v (max_v),
    .frac  (frac_in),
    .pick  (pick)
  );

  motion_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .upd       (sample_valid),
    .clr       (total_clear),
    .pick      (pick),
    .ref_count (ref_count),
    .vel_q     (vel_out),
    .disp_q    (disp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= '0;
      fixed_out <= '0;
    end else if (sample_valid) begin
      int_out   <= pick;
      fixed_out <= FIX_W'({pick, frac_in});
    end
  end
endmodule

// File: rtl/phase_count_selector_chk.sv
module phase_count_selector_chk #(
  parameter int NUM_PH = 8,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 3,
  parameter int ACC_W  = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sample_valid,
  input logic                      total_clear,
  input logic [NUM_PH*CNT_W-1:0]   phase_counts,
  input logic [FRAC_W-1:0]         frac_in,
  input logic [CNT_W-1:0]          ref_count,
  input logic [CNT_W-1:0]          int_out,
  input logic [CNT_W+FRAC_W-1:0]   fixed_out,
  input logic [CNT_W-1:0]          vel_out,
  input logic [ACC_W-1:0]          disp_out
);
  logic [CNT_W-1:0] lo_c, hi_c;
  always_comb begin
    lo_c = phase_counts[CNT_W-1:0];
    hi_c = phase_counts[CNT_W-1:0];
    for (int k = 1; k < NUM_PH; k++) begin
      lo_c = (phase_counts[k*CNT_W +: CNT_W] < lo_c) ? phase_counts[k*CNT_W +: CNT_W] : lo_c;
      hi_c = (phase_counts[k*CNT_W +: CNT_W] > hi_c) ? phase_counts[k*CNT_W +: CNT_W] : hi_c;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (int_out == '0 && fixed_out == '0 && vel_out == '0 && disp_out == '0));

  // R2
  candidate_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> (int_out == $past(lo_c) || int_out == $past(hi_c) - CNT_W'(1)));

  // R5
  word_pack_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> (fixed_out[FRAC_W-1:0] == $past(frac_in) &&
                      fixed_out[CNT_W+FRAC_W-1:FRAC_W] == int_out));

  // R6
  vel_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> (vel_out == int_out - $past(ref_count)));

  // R7
  accum_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !total_clear) |=> (disp_out == $past(disp_out) + ACC_W'(signed'(vel_out))));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    total_clear |=> (disp_out == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(int_out) && $stable(fixed_out) && $stable(vel_out)));
endmodule

bind phase_count_selector phase_count_selector_chk #(
  .NUM_PH(NUM_PH), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
) u_chk (.*);

// File: tb/tb_phase_count_selector.sv
module tb_phase_count_selector;
  localparam int NUM_PH = 8;
  localparam int CNT_W  = 32;
  localparam int FRAC_W = 3;
  localparam int ACC_W  = 32;

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  dn1;
    logic [7:0]  dn2;
    logic [7:0]  up1;
    logic [2:0]  frac;
    logic [31:0] refc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h3E,   8'h01, 8'h00, 8'h00, 3'd7, 32'h40},
    '{32'h50,   8'h00, 8'h00, 8'h00, 3'd0, 32'h40},
    '{32'h50,   8'h00, 8'h04, 8'h00, 3'd3, 32'h4F},
    '{32'h20,   8'h00, 8'h10, 8'h00, 3'd0, 32'h10},
    '{32'h1000, 8'hF0, 8'h00, 8'h00, 3'd5, 32'h1000},
    '{32'h3E,   8'h00, 8'h00, 8'h02, 3'd2, 32'h3E},
    '{32'h30,   8'h00, 8'h00, 8'h00, 3'd4, 32'h30}
  };

  logic clk = 0, rst = 1, sample_valid = 0, total_clear = 0;
  logic [NUM_PH*CNT_W-1:0] phase_counts = '0;
  logic [FRAC_W-1:0] frac_in = '0;
  logic [CNT_W-1:0] ref_count = '0;
  logic [CNT_W-1:0] int_out, vel_out;
  logic [CNT_W+FRAC_W-1:0] fixed_out;
  logic [ACC_W-1:0] disp_out;

  int checks = 0, errors = 0;
  logic [ACC_W-1:0] exp_disp = '0;
  logic [CNT_W-1:0] exp_int, exp_vel;

  always #2.5 clk = ~clk;

  phase_count_selector #(.NUM_PH(NUM_PH), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] model_pick(vec_t v);
    logic [CNT_W-1:0] lo, hi, c;
    lo = '1; hi = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      c = v.base - CNT_W'(v.dn1[i]) - CNT_W'(2 * v.dn2[i]) + CNT_W'(v.up1[i]);
      if (c < lo) lo = c;
      if (c > hi) hi = c;
    end
    if (lo == hi - 1) return lo;       // R2
    else if (v.frac != 0) return hi - 1; // R3
    else return lo;                      // R4
  endfunction

  task automatic load(vec_t v);
    for (int i = 0; i < NUM_PH; i++)
      phase_counts[i*CNT_W +: CNT_W] = v.base - CNT_W'(v.dn1[i]) - CNT_W'(2 * v.dn2[i]) + CNT_W'(v.up1[i]);
    frac_in = v.frac;
    ref_count = v.refc;
  endtask

  task automatic strobe(bit clr);
    @(negedge clk);
    sample_valid = 1; total_clear = clr;
    @(negedge clk);
    sample_valid = 0; total_clear = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 int", 64'(int_out), 0);
    check("R1 fixed", 64'(fixed_out), 0);
    check("R1 vel", 64'(vel_out), 0);
    check("R1 disp", 64'(disp_out), 0);
    rst = 0;

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      load(VEC[n]);
      strobe(0);
      exp_int  = model_pick(VEC[n]);
      exp_vel  = exp_int - VEC[n].refc;
      exp_disp = exp_disp + ACC_W'(signed'(exp_vel));
      check("R2/R3/R4 int", 64'(int_out), 64'(exp_int));
      check("R5 fixed", 64'(fixed_out), 64'({exp_int, VEC[n].frac}));
      check("R6 vel", 64'(vel_out), 64'(exp_vel));
      check("R7 disp", 64'(disp_out), 64'(exp_disp));
    end

    // R9: data change without strobe has no effect
    load(VEC[0]);
    repeat (3) @(negedge clk);
    check("R9 int hold", 64'(int_out), 64'(exp_int));
    check("R9 fixed hold", 64'(fixed_out), 64'({exp_int, VEC[NV-1].frac}));
    check("R9 vel hold", 64'(vel_out), 64'(exp_vel));
    check("R9 disp hold", 64'(disp_out), 64'(exp_disp));

    // R8: clear together with strobe
    load(VEC[2]);
    strobe(1);
    exp_int = model_pick(VEC[2]);
    exp_vel = exp_int - VEC[2].refc;
    exp_disp = '0;
    check("R8 disp cleared", 64'(disp_out), 0);
    check("R8 int updates", 64'(int_out), 64'(exp_int));
    check("R8 vel updates", 64'(vel_out), 64'(exp_vel));

    // R7 after clear: accumulate a negative step
    load(VEC[0]);
    strobe(0);
    exp_int = model_pick(VEC[0]);
    exp_vel = exp_int - VEC[0].refc;
    exp_disp = ACC_W'(signed'(exp_vel));
    check("R7 disp negative", 64'(disp_out), 64'(exp_disp));

    // R8: clear alone, others hold
    @(negedge clk); total_clear = 1;
    @(negedge clk); total_clear = 0;
    check("R8 clear alone", 64'(disp_out), 0);
    check("R9 int held on clear", 64'(int_out), 64'(exp_int));

    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 int mid reset", 64'(int_out), 0);
    check("R1 vel mid reset", 64'(vel_out), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule